// File: doc/BRIEF.md
# Instruction Cache Start-Up Invalidation Sequencer

After reset this block holds the processor core and the data cache in a stall. While they are stalled it walks the instruction cache's valid-bit array and clears one entry per clock. The stall lasts a fixed number of cycles, 512 by default, counted from the release of reset. When that count runs out, the block drops the stall. In the same cycle it issues one start-up instruction fetch to a reset vector.

The reset vector is the memory base value present on `mem_base` while reset is asserted. Changes to `mem_base` after reset is released do not move the vector. Fetch requests from the core are discarded while the sequence runs. Once the start-up fetch has gone out, the block passes core requests straight through to the fetch port.

Top module: `icache_boot_seq`

## Requirements
- R1: `stall_o` is 1 in every cycle in which `rst` is 1. After `rst` falls, `stall_o` is 1 for exactly TOTAL_CYCLES (default 512) consecutive cycles and is 0 from then on.
- R2: `vclr_we_o` is 1 in the first NUM_BLOCKS cycles after reset release, and only there. In those cycles `vclr_idx_o` counts 0, 1, 2, … NUM_BLOCKS-1, one index per cycle.
- R3: The reset vector equals the `mem_base` value sampled at the last clock edge at which `rst` was 1. Later changes of `mem_base` have no effect on it.
- R4: In the first cycle with `stall_o` at 0, `fetch_req_o` is 1 for exactly that one cycle and `fetch_addr_o` equals the reset vector. In that cycle the core request is ignored.
- R5: While `stall_o` is 1, `fetch_req_o` is 0 whatever `core_req_i` does.
- R6: From the cycle after the start-up fetch, `fetch_req_o` equals `core_req_i` and `fetch_addr_o` equals `core_addr_i` in the same cycle.
- R7: When `rst` rises part-way through the sequence, `stall_o` is 1 in that same cycle and `vclr_we_o` is 0. After release the whole sequence starts again from index 0, with the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_base | input | ADDR_W | Memory base value; sampled as the reset vector while `rst` is high |
| core_req_i | input | 1 | Fetch request from the core |
| core_addr_i | input | ADDR_W | Fetch address from the core |
| stall_o | output | 1 | Stall to the core and the data cache |
| vclr_idx_o | output | IDX_W | Index of the valid bit being cleared |
| vclr_we_o | output | 1 | Write enable that clears the valid bit at `vclr_idx_o` |
| fetch_req_o | output | 1 | Fetch request to the memory path |
| fetch_addr_o | output | ADDR_W | Fetch address to the memory path |

## Verification
Core requests and addresses are random in every cycle. Random core activity during the scan separates correct gating from leakage onto the fetch port. Random activity after boot checks that the pass-through is exact.

Each run moves `mem_base` to a new random value at reset release. This exposes a vector that tracks the live input instead of the value latched during reset.

One run is cut short by a reset at a random point in the scan. The run that follows shows whether the counter and the clear index really return to zero and whether the full stall length is counted again.

// File: rtl/icb_pkg.sv
package icb_pkg;
   typedef enum logic [1:0] {
      PH_SCAN = 2'd0,
      PH_BOOT = 2'd1,
      PH_DONE = 2'd2
   } icb_phase_t;
endpackage

// File: rtl/icb_step_counter.sv
module icb_step_counter
   import icb_pkg::*;
#(
   parameter int TOTAL_CYCLES = 512,
   localparam int CNT_W = $clog2(TOTAL_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o,
   output icb_phase_t       phase_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   icb_phase_t       phase_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         phase_q <= PH_SCAN;
      end else begin
         unique case (phase_q)
            PH_SCAN: begin
               if (cnt_q == LAST) phase_q <= PH_BOOT;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            PH_BOOT: phase_q <= PH_DONE;
            default: phase_q <= PH_DONE;
         endcase
      end
   end

   assign cnt_o   = cnt_q;
   assign phase_o = phase_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);                                                  // R1
   AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (rst)
      phase_q == PH_BOOT |=> phase_q == PH_DONE);                      // R4
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
      phase_q == PH_DONE |=> phase_q == PH_DONE);                      // R6
endmodule

// File: rtl/icb_vector_latch.sv
module icb_vector_latch #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] vec_o
);
   logic [ADDR_W-1:0] vec_q;

   always_ff @(posedge clk) begin
      if (rst) vec_q <= base_i;
   end

   assign vec_o = vec_q;

   AST_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(vec_q));                                 // R3
endmodule

// File: rtl/icb_fetch_mux.sv
module icb_fetch_mux
   import icb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  icb_phase_t        phase_i,
   input  logic              rst,
   input  logic [ADDR_W-1:0] vec_i,
   input  logic              core_req_i,
   input  logic [ADDR_W-1:0] core_addr_i,
   output logic              fetch_req_o,
   output logic [ADDR_W-1:0] fetch_addr_o
);
   always_comb begin
      fetch_req_o  = 1'b0;
      fetch_addr_o = core_addr_i;
      if (!rst) begin
         unique case (phase_i)
            PH_BOOT: begin
               fetch_req_o  = 1'b1;
               fetch_addr_o = vec_i;
            end
            PH_DONE: fetch_req_o = core_req_i;
            default: fetch_req_o = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/icache_boot_seq.sv
module icache_boot_seq
   import icb_pkg::*;
#(
   parameter  int ADDR_W       = 32,
   parameter  int NUM_BLOCKS   = 256,
   parameter  int TOTAL_CYCLES = 512,
   localparam int IDX_W        = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
   localparam int CNT_W        = $clog2(TOTAL_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] mem_base,
   input  logic              core_req_i,
   input  logic [ADDR_W-1:0] core_addr_i,
   output logic              stall_o,
   output logic [IDX_W-1:0]  vclr_idx_o,
   output logic              vclr_we_o,
   output logic              fetch_req_o,
   output logic [ADDR_W-1:0] fetch_addr_o
);
   if (NUM_BLOCKS < 1)            $error("NUM_BLOCKS must be at least 1");
   if (NUM_BLOCKS > TOTAL_CYCLES) $error("scan longer than TOTAL_CYCLES");
   if (ADDR_W < 1)                $error("ADDR_W must be positive");

   logic [CNT_W-1:0]  cnt;
   icb_phase_t        phase;
   logic [ADDR_W-1:0] vec;
   logic              in_clear;

   icb_step_counter #(.TOTAL_CYCLES(TOTAL_CYCLES)) u_cnt (
      .clk(clk), .rst(rst), .cnt_o(cnt), .phase_o(phase)
   );

   icb_vector_latch #(.ADDR_W(ADDR_W)) u_vec (
      .clk(clk), .rst(rst), .base_i(mem_base), .vec_o(vec)
   );

   icb_fetch_mux #(.ADDR_W(ADDR_W)) u_mux (
      .phase_i(phase), .rst(rst), .vec_i(vec),
      .core_req_i(core_req_i), .core_addr_i(core_addr_i),
      .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o)
   );

   if (NUM_BLOCKS == TOTAL_CYCLES) begin : g_full_scan
      assign in_clear = (phase == PH_SCAN);
   end else begin : g_part_scan
      assign in_clear = (phase == PH_SCAN) && (cnt < CNT_W'(NUM_BLOCKS));
   end

   assign stall_o    = rst || (phase == PH_SCAN);
   assign vclr_we_o  = in_clear && !rst;
   assign vclr_idx_o = cnt[IDX_W-1:0];

   AST_CLEAR_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
      vclr_we_o |-> stall_o);                                          // R2
   AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (rst)
      vclr_we_o && $past(vclr_we_o) |-> vclr_idx_o == $past(vclr_idx_o) + 1'b1); // R2
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> stall_o && vclr_we_o && vclr_idx_o == '0);        // R7
   AST_NO_FETCH_STALLED: assert property (@(posedge clk) disable iff (rst)
      stall_o |-> !fetch_req_o);                                       // R5
   AST_BOOT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
      $fell(stall_o) |-> fetch_req_o && fetch_addr_o == vec);          // R4
endmodule

// File: tb/sim_icache_boot_seq.sv
module sim_icache_boot_seq;
   localparam int AW = 32;
   localparam int NB = 256;
   localparam int TC = 512;
   localparam int IW = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_base = '0;
   logic          core_req = 1'b0;
   logic [AW-1:0] core_addr = '0;
   logic          stall, vclr_we, freq;
   logic [IW-1:0] vclr_idx;
   logic [AW-1:0] faddr;

   int total = 0;
   int bad   = 0;
   int seed  = 1301;

   always #2 clk = ~clk;

   icache_boot_seq #(.ADDR_W(AW), .NUM_BLOCKS(NB), .TOTAL_CYCLES(TC)) u0 (
      .clk(clk), .rst(rst), .mem_base(mem_base),
      .core_req_i(core_req), .core_addr_i(core_addr),
      .stall_o(stall), .vclr_idx_o(vclr_idx), .vclr_we_o(vclr_we),
      .fetch_req_o(freq), .fetch_addr_o(faddr)
   );

   function automatic logic exp_stall(int k);   return k < TC;  endfunction
   function automatic logic exp_we(int k);      return k < NB;  endfunction
   function automatic logic exp_freq(int k, logic creq);
      if (k == TC) return 1'b1;
      if (k > TC)  return creq;
      return 1'b0;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive_core();
      core_req  = 1'($urandom_range(0, 1));
      core_addr = $urandom();
   endtask

   task automatic run_seq(input logic [AW-1:0] base, input int abort_at);
      @(negedge clk);
      rst = 1'b1; mem_base = base; drive_core();
      #1 chk(stall == 1'b1, "R1 stall in reset", AW'(stall), 1);
      chk(freq == 1'b0, "R5 no fetch in reset", AW'(freq), 0);
      repeat (3) begin @(negedge clk); drive_core(); end
      for (int k = 0; k <= TC + 24; k++) begin
         @(negedge clk);
         if (k == 0) begin
            rst = 1'b0;
            mem_base = $urandom();
         end
         drive_core();
         if (k == abort_at) begin
            rst = 1'b1;
            #1 chk(stall == 1'b1, "R7 stall at once", AW'(stall), 1);
            chk(vclr_we == 1'b0, "R7 clear off in reset", AW'(vclr_we), 0);
            return;
         end
         #1;
         chk(stall == exp_stall(k), "R1 stall length", AW'(stall), AW'(exp_stall(k)));
         chk(vclr_we == exp_we(k), "R2 clear enable", AW'(vclr_we), AW'(exp_we(k)));
         if (k < NB)
            chk(vclr_idx == IW'(k), "R2 clear index", AW'(vclr_idx), AW'(k));
         if (k < TC)
            chk(freq == 1'b0, "R5 core request ignored", AW'(freq), 0);
         else if (k == TC) begin
            chk(freq == 1'b1, "R4 boot pulse", AW'(freq), 1);
            chk(faddr == base, "R3 R4 reset vector", faddr, base);
         end else begin
            chk(freq == exp_freq(k, core_req), "R6 pass request", AW'(freq), AW'(core_req));
            if (core_req)
               chk(faddr == core_addr, "R6 pass address", faddr, core_addr);
         end
      end
   endtask

   initial begin
      void'($urandom(seed));
      run_seq(32'h8000_0000, -1);
      run_seq($urandom(), 17 + int'($urandom_range(0, 300)));
      run_seq($urandom(), -1);
      run_seq(32'h0000_0000, 1);
      run_seq(32'hFFFF_FFC0, -1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule